// File: doc/BRIEF.md
# Vehicle-Triggered Junction Light Sequencer

This block drives the lamps at a crossing of a main road and a side road. When the junction is idle, the main road shows green and the side road shows red. A vehicle detector on the side road feeds a single input. The first clock edge that sees that input high starts a timed cycle of fixed length. During that cycle the main road goes through amber to red, the side road gets green and then amber, and the junction then returns to its idle state.

All of the timing comes from one cycle counter, and a run flag qualifies it. The flag is set when the detector fires while the junction is idle. The counter then advances on every clock edge, whatever the detector does, until it reaches its final count. On that edge it wraps to zero and clears the flag. Each lamp phase is a range of that single count, so the lamp outputs are a pure decode of two registers.

Top module: `tls_junction_seq`

## Requirements
- R1: Reset is asynchronous and active low. While `rst_n` is low, `main_lamp` is 3'b001 and `side_lamp` is 3'b100, with no clock edge needed. The lamp bit encoding is bit 2 = red, bit 1 = amber, bit 0 = green.
- R2: When idle with `veh_sense` low, the outputs stay at main 3'b001 and side 3'b100, and the internal count is held at zero.
- R3: A rising clock edge that samples `veh_sense` high while idle starts a cycle at count 0. Right after that edge, `main_lamp` is 3'b010 and `side_lamp` is 3'b100.
- R4: While a cycle runs, the count advances by one on every rising edge, whatever the level of `veh_sense`. The lamps follow the count: for counts 0 to 3, main is 3'b010 and side is 3'b100; for counts 4 to 49, main is 3'b100 and side is 3'b001; for counts 50 to 53, main is 3'b100 and side is 3'b010.
- R5: The edge that leaves count 53 returns the block to idle, with the count at 0, main at 3'b001 and side at 3'b100. A full cycle therefore lasts 54 clock cycles.
- R6: Detector pulses during a running cycle are ignored. They neither restart nor stretch the cycle.
- R7: If `veh_sense` is high on the edge that leaves count 53, the block spends exactly one cycle idle and then starts a new cycle on the following edge.
- R8: Each lamp output has exactly one bit set. The two roads never show green or amber at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| veh_sense | input | 1 | Vehicle detector, active high |
| main_lamp | output | 3 | Main-road lamps {red, amber, green} |
| side_lamp | output | 3 | Side-road lamps {red, amber, green} |

## Verification
The assertions check the following on every clock: each lamp output is one-hot, the two roads never show a conflict, the lamps are at their idle values whenever the run flag is clear, the counter steps by one or wraps, and an idle edge with the detector high starts a cycle at zero. Some behaviour shows only over time and at the ports, so only the directed scenarios can demonstrate it: the exact phase boundaries at counts 3/4 and 49/50, the 54-cycle length, the single idle cycle between back-to-back cycles, and that reset takes effect without a clock edge.

// File: rtl/tls_pkg.sv
package tls_pkg;

  localparam int LAMP_W = 3;

  typedef enum logic [1:0] {
    PH_REST       = 2'd0,
    PH_MAIN_AMBER = 2'd1,
    PH_SIDE_GREEN = 2'd2,
    PH_SIDE_AMBER = 2'd3
  } phase_e;

  // lamp bit positions: [2]=red [1]=amber [0]=green
  localparam logic [LAMP_W-1:0] LAMP_RED   = 3'b100;
  localparam logic [LAMP_W-1:0] LAMP_AMBER = 3'b010;
  localparam logic [LAMP_W-1:0] LAMP_GREEN = 3'b001;

  // Phase from count: counts [0, main_amber_end] are main amber,
  // (main_amber_end, side_green_end] are side green, the rest side amber.
  function automatic phase_e phase_of(input logic running,
                                      input int unsigned cnt,
                                      input int unsigned main_amber_end,
                                      input int unsigned side_green_end);
    if (!running)                     return PH_REST;
    else if (cnt <= main_amber_end)   return PH_MAIN_AMBER;
    else if (cnt <= side_green_end)   return PH_SIDE_GREEN;
    else                              return PH_SIDE_AMBER;
  endfunction

  function automatic logic [LAMP_W-1:0] main_lamp_of(input phase_e ph);
    case (ph)
      PH_REST:       return LAMP_GREEN;
      PH_MAIN_AMBER: return LAMP_AMBER;
      default:       return LAMP_RED;
    endcase
  endfunction

  function automatic logic [LAMP_W-1:0] side_lamp_of(input phase_e ph);
    case (ph)
      PH_SIDE_GREEN: return LAMP_GREEN;
      PH_SIDE_AMBER: return LAMP_AMBER;
      default:       return LAMP_RED;
    endcase
  endfunction

endpackage

// File: rtl/tls_cycle_counter.sv
module tls_cycle_counter #(
  parameter int CNT_W    = 7,
  parameter int LAST_CNT = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             start_evt,
  output logic             wrap_evt
);

  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST_CNT);

  assign start_evt = !running && trigger;
  assign wrap_evt  = running && (count == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
    end else if (wrap_evt) begin
      running <= 1'b0;
      count   <= '0;
    end else if (running) begin
      count   <= count + 1'b1;
    end else if (start_evt) begin
      running <= 1'b1;
    end
  end

endmodule

// File: rtl/tls_phase_decode.sv
module tls_phase_decode
  import tls_pkg::*;
#(
  parameter int CNT_W          = 7,
  parameter int MAIN_AMBER_END = 3,
  parameter int SIDE_GREEN_END = 49
) (
  input  logic             running,
  input  logic [CNT_W-1:0] count,
  output phase_e           phase
);

  always_comb begin
    phase = phase_of(running, int'(unsigned'(count)),
                     MAIN_AMBER_END, SIDE_GREEN_END);
  end

endmodule

// File: rtl/tls_lamp_encode.sv
module tls_lamp_encode
  import tls_pkg::*;
(
  input  phase_e            phase,
  output logic [LAMP_W-1:0] main_lamp,
  output logic [LAMP_W-1:0] side_lamp
);

  always_comb begin
    main_lamp = main_lamp_of(phase);
    side_lamp = side_lamp_of(phase);
  end

endmodule

// File: rtl/tls_junction_seq.sv
module tls_junction_seq
  import tls_pkg::*;
#(
  parameter int CNT_W          = 7,
  parameter int MAIN_AMBER_LEN = 4,
  parameter int SIDE_AMBER_LEN = 4,
  parameter int LAST_CNT       = 53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       veh_sense,
  output logic [2:0] main_lamp,
  output logic [2:0] side_lamp
);

  localparam int MAIN_AMBER_END = MAIN_AMBER_LEN - 1;
  localparam int SIDE_GREEN_END = LAST_CNT - SIDE_AMBER_LEN;

  logic             cyc_running;
  logic [CNT_W-1:0] cyc_count;
  logic             cyc_start;
  logic             cyc_wrap;
  phase_e           cur_phase;

  tls_cycle_counter #(
    .CNT_W    (CNT_W),
    .LAST_CNT (LAST_CNT)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigger   (veh_sense),
    .running   (cyc_running),
    .count     (cyc_count),
    .start_evt (cyc_start),
    .wrap_evt  (cyc_wrap)
  );

  tls_phase_decode #(
    .CNT_W          (CNT_W),
    .MAIN_AMBER_END (MAIN_AMBER_END),
    .SIDE_GREEN_END (SIDE_GREEN_END)
  ) u_decode (
    .running (cyc_running),
    .count   (cyc_count),
    .phase   (cur_phase)
  );

  tls_lamp_encode u_lamps (
    .phase     (cur_phase),
    .main_lamp (main_lamp),
    .side_lamp (side_lamp)
  );

endmodule

// File: rtl/tls_junction_sva.sv
module tls_junction_sva #(
  parameter int CNT_W    = 7,
  parameter int LAST_CNT = 53
) (
  input logic             clk,
  input logic             rst_n,
  input logic             veh_sense,
  input logic [2:0]       main_lamp,
  input logic [2:0]       side_lamp,
  input logic             cyc_running,
  input logic [CNT_W-1:0] cyc_count,
  input logic             cyc_wrap
);

  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST_CNT);

  a_r2_idle_lamps: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_running |-> (main_lamp == 3'b001 && side_lamp == 3'b100));

  a_r2_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_running |-> (cyc_count == '0));

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_running && veh_sense) |=> (cyc_running && cyc_count == '0));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_running && cyc_count != LAST_V) |=>
      (cyc_running && cyc_count == $past(cyc_count) + 1'b1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> (!cyc_running && cyc_count == '0));

  a_r8_main_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(main_lamp) == 1);

  a_r8_side_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(side_lamp) == 1);

  a_r8_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_lamp[2] == 1'b0 && side_lamp[2] == 1'b0));

endmodule

bind tls_junction_seq tls_junction_sva #(
  .CNT_W    (CNT_W),
  .LAST_CNT (LAST_CNT)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .veh_sense   (veh_sense),
  .main_lamp   (main_lamp),
  .side_lamp   (side_lamp),
  .cyc_running (cyc_running),
  .cyc_count   (cyc_count),
  .cyc_wrap    (cyc_wrap)
);

// File: tb/tls_junction_seq_test.sv
`timescale 1ns/1ps
module tls_junction_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       veh_sense = 1'b0;
  logic [2:0] main_lamp;
  logic [2:0] side_lamp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tls_junction_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .veh_sense (veh_sense),
    .main_lamp (main_lamp),
    .side_lamp (side_lamp)
  );

  // expected lamps for running step k, from the phase plan
  function automatic logic [2:0] exp_main(input int k);
    return (k <= 3) ? 3'b010 : 3'b100;
  endfunction
  function automatic logic [2:0] exp_side(input int k);
    if (k <= 3)  return 3'b100;
    if (k <= 49) return 3'b001;
    return 3'b010;
  endfunction

  task automatic check(input string req, input logic [2:0] m, input logic [2:0] s);
    checks++;
    if (main_lamp !== m || side_lamp !== s) begin
      errors++;
      $display("FAIL %s: main=%b side=%b expected main=%b side=%b",
               req, main_lamp, side_lamp, m, s);
    end
  endtask

  // one clock edge, then sample 1 ns later
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_sense(input logic v);
    @(negedge clk);
    veh_sense = v;
  endtask

  // R8 conflict check every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ($countones(main_lamp) != 1 || $countones(side_lamp) != 1 ||
          (main_lamp[2] == 1'b0 && side_lamp[2] == 1'b0)) begin
        errors++;
        $display("FAIL R8: main=%b side=%b expected one-hot, at least one red",
                 main_lamp, side_lamp);
      end
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    check("R1 in reset", 3'b001, 3'b100);
    repeat (2) tick();
    check("R1 held in reset", 3'b001, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    set_sense(1'b0);
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R2 idle", 3'b001, 3'b100);
    end
  endtask

  // full cycle; sense_mid raises the detector for steps 10..20 (R6)
  task automatic t_cycle(input bit sense_mid, input string tag);
    set_sense(1'b1);
    tick();
    check("R3 start", 3'b010, 3'b100);
    set_sense(1'b0);
    for (int k = 1; k <= 53; k++) begin
      if (sense_mid && (k == 10)) veh_sense = 1'b1;
      if (sense_mid && (k == 21)) veh_sense = 1'b0;
      tick();
      check(tag, exp_main(k), exp_side(k));
      @(negedge clk);
    end
    tick();
    check("R5 back to rest", 3'b001, 3'b100);
    tick();
    check("R5 stays at rest", 3'b001, 3'b100);
  endtask

  task automatic t_back_to_back();
    set_sense(1'b1);
    tick();
    check("R7 first start", 3'b010, 3'b100);
    for (int k = 1; k <= 53; k++) begin
      tick();
      check("R7 steps", exp_main(k), exp_side(k));
    end
    tick();
    check("R7 one idle cycle", 3'b001, 3'b100);
    tick();
    check("R7 restart", 3'b010, 3'b100);
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R7 second cycle", exp_main(k), exp_side(k));
    end
    set_sense(1'b0);
  endtask

  task automatic t_async_mid();
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R1 async mid-cycle", 3'b001, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R2 after reset", 3'b001, 3'b100);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_cycle(1'b0, "R4 phase plan");
    t_cycle(1'b1, "R6 pulses ignored");
    t_back_to_back();
    t_async_mid();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    done = 1;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule